// File: doc/BRIEF.md
# Serial Quad Trim-DAC Register Controller

This block is the digital side of a four-channel, 8-bit trimming DAC driven over a three-wire serial port: a serial clock, a chip select and a data input, plus a data output that the block only drives while it is selected. Every channel has two registers. One is a volatile control register that sets the code driven to its DAC. The other is a non-volatile shadow store, modelled here as flip-flops. Each serial frame carries a start bit, a channel address and a data byte. While the new byte comes in, the old setting of that channel is shifted out. The new byte takes effect as a temporary setting. It is also committed to the shadow store if the program strobe was raised in time and the programming supply reports ready.

Releasing the chip select works as a reset of all temporary state: every control register is reloaded from its shadow value. A host can try out settings freely, then store the ones it wants to keep. It can read a setting back and drop the chip select before the frame ends. The read is destructive, and the stored value comes back at that point. All serial inputs are sampled by the system clock. The serial clock is edge-detected, and the chip select passes through a sample-count glitch filter.

Top module: `trim_dac_ctrl`

## Requirements
- R1: After reset, every control register and every shadow register holds NV_INIT (default 8'h80), so every DAC code equals NV_INIT without any serial clock activity, and the data output is disabled.
- R2: A frame is a 1 start bit, then address bit A0, then A1, each sampled on a serial clock rising edge. The channel index is A0 + 2*A1: A0=0,A1=0 selects code slot 0 (dac_codes[7:0]), A0=1,A1=0 selects slot 1, A0=0,A1=1 selects slot 2 and A0=1,A1=1 selects slot 3.
- R3: The eight data bits follow the address, least significant bit first. The addressed DAC code takes the new byte on the serial clock rising edge after D7, and no other channel's code changes. While chip select is active, DAC codes change only in response to a serial clock rising edge.
- R4: After A1, the addressed channel's current control value appears on sdo, least significant bit first. Bit k is valid from the edge that precedes Dk until the edge that samples Dk. Outside the data bits, sdo is 0.
- R5: sdo_oe is 1 exactly while the filtered chip select is high, and 0 while it is low.
- R6: When the filtered chip select falls, all four control registers are reloaded from their shadow registers on the next system clock.
- R7: A frame that the chip select ends before the edge after D7 writes nothing. The addressed channel reads back its shadow value afterwards.
- R8: The shadow register of the addressed channel takes the new byte only if prog is seen high at some time after the start-bit edge and no later than the edge after D7. A strobe raised after that edge leaves the shadow unchanged.
- R9: A change of the chip select input is accepted only after it has stayed different from the filtered value for CS_FILT consecutive system clocks (default 5). A shorter low pulse causes no restore.
- R10: A commit also requires vpp_ready high on the edge after D7. Without it, the write is temporary only.
- R11: The two serial clock edges after D7 are never taken as a start bit, whatever the data input holds. The next frame can start on the third edge after D7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset (power-up load) |
| sclk | input | 1 | Serial clock, already synchronous to clk |
| cs | input | 1 | Chip select, active high, unfiltered |
| di | input | 1 | Serial data input |
| prog | input | 1 | Program strobe, active high |
| vpp_ready | input | 1 | Programming supply is up and stable |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for sdo (tri-state control) |
| dac_codes | output | NCH*DW | Four DAC codes, slot i at [i*DW +: DW] |

## Verification
The bench builds the block with its defaults: four channels, 8-bit codes, a shadow power-up value of 8'h80 and a chip-select filter of five samples. A serial bit lasts four system clocks. With these values, a low pulse of three system clocks on the chip select falls inside the filter window, and a full release falls well outside it. Both the glitch and the genuine restore can therefore be driven in a single run. The serial timing also lets the program strobe be placed on either side of the edge after D7.

// File: rtl/trim_dac_pkg.sv
// Shared types for the serial trim-DAC controller.
// Assumes: no state beyond the frame sequencer's phases needs sharing.
package trim_dac_pkg;

    // Phases of one serial frame, counted in serial clock rising edges.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,   // waiting for a 1 start bit
        PH_ADDR  = 3'd1,   // receiving channel address, LSB first
        PH_DATA  = 3'd2,   // receiving data, shifting old value out
        PH_APPLY = 3'd3,   // next edge applies / commits the byte
        PH_GAP   = 3'd4    // last edge of the mandatory gap
    } frame_ph_t;

endpackage

// File: rtl/trim_cs_filter.sv
// Chip-select glitch filter.
// The filtered output follows the raw input only after the raw value
// has differed from it for FILT consecutive system clocks.
// Assumes: cs_raw is synchronous to clk.
module trim_cs_filter #(
    parameter int FILT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_raw,
    output logic cs_filt
);
    localparam int CW = $clog2(FILT + 1);

    logic [CW-1:0] run_cnt;

    // Count disagreeing samples; flip the output once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_filt <= 1'b0;
            run_cnt <= '0;
        end else if (cs_raw == cs_filt) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT - 1)) begin
            cs_filt <= cs_raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/trim_frame_engine.sv
// Serial frame sequencer.
// Decodes start bit, address and data on serial clock rising edges.
// Shifts out the addressed register's value and raises a write (and
// possibly a commit) on the edge after D7.
// Assumes: sclk_rise is a one-clock pulse; AW >= 2.
module trim_frame_engine
    import trim_dac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int AW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_filt,
    input  logic              sclk_rise,
    input  logic              di,
    input  logic              prog,
    input  logic              vpp_ready,
    input  logic [NCH*DW-1:0] ctrl_flat,
    output logic              sdo,
    output logic              wr_en,
    output logic              commit,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data
);
    localparam int CW = $clog2(DW);

    frame_ph_t     phase;
    logic [CW-1:0] bit_cnt;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] rx_q;
    logic [DW-1:0] tx_q;
    logic          prog_seen;
    logic [AW-1:0] addr_next;
    logic          prog_ok;

    assign addr_next = {di, addr_q[AW-1:1]};
    assign prog_ok   = prog_seen | prog;

    // Sequence the frame; everything clears while chip select is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_filt) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            addr_q    <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            prog_seen <= 1'b0;
        end else begin
            if (prog && phase != PH_IDLE && phase != PH_GAP) begin
                prog_seen <= 1'b1;
            end
            if (sclk_rise) begin
                case (phase)
                    PH_IDLE: begin
                        if (di) begin
                            phase     <= PH_ADDR;
                            bit_cnt   <= '0;
                            prog_seen <= 1'b0;
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= addr_next;
                        if (bit_cnt == CW'(AW - 1)) begin
                            tx_q    <= ctrl_flat[addr_next*DW +: DW];
                            bit_cnt <= '0;
                            phase   <= PH_DATA;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        rx_q <= {di, rx_q[DW-1:1]};
                        tx_q <= {1'b0, tx_q[DW-1:1]};
                        if (bit_cnt == CW'(DW - 1)) begin
                            phase <= PH_APPLY;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_APPLY: phase <= PH_GAP;
                    default:  phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign sdo     = (phase == PH_DATA) ? tx_q[0] : 1'b0;
    assign wr_en   = cs_filt && sclk_rise && (phase == PH_APPLY);
    assign commit  = wr_en && prog_ok && vpp_ready;
    assign wr_addr = addr_q;
    assign wr_data = rx_q;
endmodule

// File: rtl/trim_reg_bank.sv
// Control and shadow register bank, one pair per channel.
// Control registers track the shadow store while chip select is low.
// Assumes: wr_en and commit are single-cycle pulses; commit implies wr_en.
module trim_reg_bank #(
    parameter int          NCH     = 4,
    parameter int          DW      = 8,
    parameter logic [DW-1:0] NV_INIT = 8'h80,
    localparam int AW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_filt,
    input  logic              wr_en,
    input  logic              commit,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH*DW-1:0] ctrl_flat,
    output logic [NCH*DW-1:0] nv_flat
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [DW-1:0] ctrl_q;
        logic [DW-1:0] nv_q;
        logic          hit;

        assign hit = (wr_addr == AW'(ch));

        // Shadow store: power-up contents, then committed bytes only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nv_q <= NV_INIT;
            end else if (commit && hit) begin
                nv_q <= wr_data;
            end
        end

        // Control register: restored while deselected, else serial writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q <= NV_INIT;
            end else if (!cs_filt) begin
                ctrl_q <= nv_q;
            end else if (wr_en && hit) begin
                ctrl_q <= wr_data;
            end
        end

        assign ctrl_flat[ch*DW +: DW] = ctrl_q;
        assign nv_flat[ch*DW +: DW]   = nv_q;
    end
endmodule

// File: rtl/trim_dac_ctrl.sv
// Top of the serial quad trim-DAC controller.
// Edge-detects the serial clock, filters chip select and ties the frame
// sequencer to the register bank.
// Assumes: sclk, cs, di, prog and vpp_ready are synchronous to clk, and
// each sclk level lasts at least one clk.
module trim_dac_ctrl #(
    parameter int          NCH     = 4,
    parameter int          DW      = 8,
    parameter int          CS_FILT = 5,
    parameter logic [DW-1:0] NV_INIT = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs,
    input  logic              di,
    input  logic              prog,
    input  logic              vpp_ready,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [NCH*DW-1:0] dac_codes
);
    localparam int AW = $clog2(NCH);

    logic              sclk_q;
    logic              sclk_rise;
    logic              cs_filt;
    logic              wr_en;
    logic              commit;
    logic [AW-1:0]     wr_addr;
    logic [DW-1:0]     wr_data;
    logic [NCH*DW-1:0] ctrl_flat;
    logic [NCH*DW-1:0] nv_flat;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign sclk_rise = sclk & ~sclk_q;

    trim_cs_filter #(.FILT(CS_FILT)) u_csf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_raw  (cs),
        .cs_filt (cs_filt)
    );

    trim_frame_engine #(.NCH(NCH), .DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_filt   (cs_filt),
        .sclk_rise (sclk_rise),
        .di        (di),
        .prog      (prog),
        .vpp_ready (vpp_ready),
        .ctrl_flat (ctrl_flat),
        .sdo       (sdo),
        .wr_en     (wr_en),
        .commit    (commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    trim_reg_bank #(.NCH(NCH), .DW(DW), .NV_INIT(NV_INIT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_filt   (cs_filt),
        .wr_en     (wr_en),
        .commit    (commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctrl_flat (ctrl_flat),
        .nv_flat   (nv_flat)
    );

    assign sdo_oe    = cs_filt;
    assign dac_codes = ctrl_flat;
endmodule

// File: rtl/trim_dac_ctrl_chk.sv
// Temporal checks for trim_dac_ctrl, attached with bind.
// Assumes: observes internal nets of the top by name.
module trim_dac_ctrl_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              cs_filt,
    input logic              sclk_rise,
    input logic              commit,
    input logic [NCH*DW-1:0] dac_codes,
    input logic [NCH*DW-1:0] nv_flat
);
    AST_RESTORE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_filt) |=> (dac_codes == nv_flat)); // R6

    AST_DAC_HOLDS_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_filt && !sclk_rise) |=> $stable(dac_codes)); // R3

    AST_SHADOW_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(nv_flat)); // R8

    AST_FILTER_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_filt) |-> (cs_filt == $past(cs))); // R9
endmodule

bind trim_dac_ctrl trim_dac_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .cs_filt   (cs_filt),
    .sclk_rise (sclk_rise),
    .commit    (commit),
    .dac_codes (dac_codes),
    .nv_flat   (nv_flat)
);

// File: tb/tb_trim_dac_ctrl.sv
// Self-checking bench for trim_dac_ctrl: a vector table of frames, then
// directed tests for restore, glitch, late strobe, supply and spacing.
module tb_trim_dac_ctrl;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int CSF = 5;
    localparam logic [7:0] INIT = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs = 1'b0;
    logic di = 1'b0;
    logic prog = 1'b0;
    logic vpp_ready = 1'b1;
    logic sdo;
    logic sdo_oe;
    logic [NCH*DW-1:0] dac_codes;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_ctrl [NCH];
    logic [7:0] m_nv   [NCH];

    // Each entry: {prog, channel[1:0], data[7:0]}
    localparam logic [10:0] VEC [6] = '{
        {1'b0, 2'd0, 8'h11}, {1'b1, 2'd1, 8'h22}, {1'b0, 2'd2, 8'h5A},
        {1'b1, 2'd3, 8'hC3}, {1'b0, 2'd0, 8'h3C}, {1'b1, 2'd2, 8'hA5}
    };

    always #5 clk = ~clk;

    trim_dac_ctrl #(.NCH(NCH), .DW(DW), .CS_FILT(CSF), .NV_INIT(INIT)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs(cs), .di(di),
        .prog(prog), .vpp_ready(vpp_ready), .sdo(sdo), .sdo_oe(sdo_oe),
        .dac_codes(dac_codes)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] code(input int ch);
        return dac_codes[ch*DW +: DW];
    endfunction

    // One serial bit: sample sdo, present di, then a rising edge.
    task automatic sbit(input logic b, output logic o);
        o = sdo;
        di = b;
        sclk = 1'b0;
        @(negedge clk); @(negedge clk);
        sclk = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic frame(input int ch, input logic [7:0] d, input bit p_early,
                         input bit p_late, input logic trail, output logic [7:0] rb);
        logic o;
        sbit(1'b1, o);
        prog = p_early;
        sbit(ch[0], o);
        sbit(ch[1], o);
        for (int k = 0; k < 8; k++) begin
            sbit(d[k], o);
            rb[k] = o;
        end
        sbit(trail, o);
        if (p_late) prog = 1'b1;
        sbit(trail, o);
        prog = 1'b0;
        sbit(1'b0, o);
    endtask

    task automatic set_cs(input logic v);
        cs = v;
        repeat (CSF + 3) @(negedge clk);
    endtask

    task automatic restore_model();
        for (int c = 0; c < NCH; c++) m_ctrl[c] = m_nv[c];
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) chk(req, 32'(code(c)), 32'(m_ctrl[c]));
    endtask

    initial begin : main
        logic [7:0] rb;
        logic o;
        for (int c = 0; c < NCH; c++) begin m_ctrl[c] = INIT; m_nv[c] = INIT; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1");
        chk("R1 oe", 32'(sdo_oe), 32'd0);
        set_cs(1'b1);
        chk("R5", 32'(sdo_oe), 32'd1);

        // Vector table: R2 addressing, R3 apply, R4 readback, R8 commit
        for (int v = 0; v < 6; v++) begin
            int ch;
            ch = int'(VEC[v][9:8]);
            frame(ch, VEC[v][7:0], VEC[v][10], 1'b0, 1'b0, rb);
            chk("R4", 32'(rb), 32'(m_ctrl[ch]));
            m_ctrl[ch] = VEC[v][7:0];
            if (VEC[v][10]) m_nv[ch] = VEC[v][7:0];
            check_all("R2 R3");
        end

        set_cs(1'b0);
        chk("R5 low", 32'(sdo_oe), 32'd0);
        restore_model();
        check_all("R6");

        // R9: short low pulse on chip select causes no restore
        set_cs(1'b1);
        frame(0, 8'h77, 1'b0, 1'b0, 1'b0, rb);
        m_ctrl[0] = 8'h77;
        cs = 1'b0;
        repeat (CSF - 2) @(negedge clk);
        cs = 1'b1;
        repeat (CSF + 3) @(negedge clk);
        chk("R9 glitch", 32'(code(0)), 32'h77);
        chk("R9 oe", 32'(sdo_oe), 32'd1);
        set_cs(1'b0);
        restore_model();
        chk("R6 after glitch", 32'(code(0)), 32'(m_nv[0]));

        // R8: program strobe raised after the edge following D7 is ignored
        set_cs(1'b1);
        frame(3, 8'h0F, 1'b0, 1'b1, 1'b0, rb);
        chk("R8 temp", 32'(code(3)), 32'h0F);
        set_cs(1'b0);
        chk("R8 late", 32'(code(3)), 32'(m_nv[3]));

        // R10: supply not ready blocks the commit
        set_cs(1'b1);
        vpp_ready = 1'b0;
        frame(1, 8'h99, 1'b1, 1'b0, 1'b0, rb);
        vpp_ready = 1'b1;
        chk("R10 temp", 32'(code(1)), 32'h99);
        set_cs(1'b0);
        chk("R10", 32'(code(1)), 32'(m_nv[1]));

        // R7: aborted frame after a temporary change
        set_cs(1'b1);
        frame(2, 8'h01, 1'b0, 1'b0, 1'b0, rb);
        sbit(1'b1, o); sbit(1'b0, o); sbit(1'b1, o);
        for (int k = 0; k < 4; k++) sbit(1'b1, o);
        chk("R7 mid", 32'(code(2)), 32'h01);
        set_cs(1'b0);
        chk("R7", 32'(code(2)), 32'(m_nv[2]));
        set_cs(1'b1);
        frame(2, 8'h33, 1'b0, 1'b0, 1'b0, rb);
        chk("R7 readback", 32'(rb), 32'(m_nv[2]));

        // R11: ones on the two edges after D7 are not a start bit
        frame(1, 8'h44, 1'b0, 1'b0, 1'b1, rb);
        frame(1, 8'h55, 1'b0, 1'b0, 1'b0, rb);
        chk("R11 readback", 32'(rb), 32'h44);
        chk("R11 apply", 32'(code(1)), 32'h55);
        set_cs(1'b0);

        // Late reset back to power-up state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) chk("R1 rerun", 32'(code(c)), 32'(INIT));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule